// File: doc/BRIEF.md
# Depth-Chained FIFO Segment Controller

This block builds one first-in first-out queue out of several equal memory segments chained in depth. Each segment has its own small storage array, its own read and write pointers, and its own full and empty flags. Only one segment at a time may accept writes, and only one may supply reads. The right to write and the right to read each move as a token around a ring of segments. Segment i passes its tokens to segment i+1, and the last segment passes them back to the first. Total capacity is the segment count times the segment depth.

A segment passes a token on with a one-cycle expansion pulse. It raises that pulse in the same cycle that it writes, or reads, its last location. The pulse has two flavours, one for the write token and one for the read token, so the receiving segment knows which token it has just gained. A first-load input, held low on exactly one segment, picks the segment that holds both tokens after reset. The queue-wide full and empty outputs are active low. Each is formed from the per-segment flags of all segments, qualified by which segment holds the relevant token. The design uses a single clock. Write and read requests are single-cycle strobes. Read data is registered and marked valid one cycle after the request.

Top module: `fifo_depth_chain`

## Requirements
- R1: While rst_n is low, and after it is released, empty_n is 0, full_n is 1 and rd_valid is 0. A word written after reset is the next word read, even if data was stored before the reset.
- R2: Words leave in exactly the order in which they were accepted, including across segment boundaries.
- R3: A write strobe while full_n is 0 is ignored. full_n stays 0, and the stored contents and their order are unchanged.
- R4: A read strobe while empty_n is 0 is ignored. rd_valid stays 0 in the following cycle and empty_n stays 0.
- R5: Exactly one segment holds the write token. A segment that writes its last location pulses its write-flavoured expansion output for one cycle and gives up the token to the next segment.
- R6: Exactly one segment holds the read token. A segment that reads its last location pulses its read-flavoured expansion output for one cycle and gives up the token to the next segment.
- R7: full_n goes to 0 after exactly NSEG*DEPTH accepted writes without reads. empty_n is 0 exactly when no unread word is stored. Both flags are never 0 at the same time.
- R8: A read and a write in the same cycle are both accepted when neither flag blocks them, and the stored count is unchanged. When the queue is full only the read is accepted. When it is empty only the write is accepted.
- R9: An accepted read sets rd_valid to 1 and places the word on rd_data in the cycle after the strobe. A cycle with no accepted read gives rd_valid 0.
- R10: After more than NSEG*DEPTH words have passed through, both tokens have returned around the ring, and ordering continues without loss or duplication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for all segments |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | DW | Word to store |
| rd_en | input | 1 | Read strobe, one word per cycle |
| rd_data | output | DW | Registered word from the last accepted read |
| rd_valid | output | 1 | rd_data holds a newly read word |
| full_n | output | 1 | Active-low composite full flag |
| empty_n | output | 1 | Active-low composite empty flag |

## Verification
The hardest situation to reach is the one where the read token and the write token sit in the same segment while that segment is partly drained from an earlier lap. In that case the segment's full and empty flags mean something different from the queue-wide state. The stimulus gets there by filling the whole ring, draining only part of it, and refilling. After that, it keeps a steady stream in which reads lag writes by a few words for more than two laps, so that every segment boundary is crossed by both tokens while the other token is nearby. Full and empty corner cycles are driven with simultaneous strobes, so the blocked-side rule of R8 is seen at both ends.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  // Expansion pulse: which token is being handed to the next segment.
  typedef struct packed {
    logic wr;
    logic rd;
  } fdc_xp_t;
endpackage

// File: rtl/fdc_seg_ram.sv
module fdc_seg_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fdc_seg_ctrl.sv
module fdc_seg_ctrl
  import fdc_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          first_load_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  fdc_xp_t       xi,
  output fdc_xp_t       xo,
  output logic          wr_go,
  output logic          rd_go,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic          wtok,
  output logic          rtok,
  output logic          full_n,
  output logic          empty_n
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wtok_q, wtok_d, rtok_q, rtok_d;
  logic          full, empty, wlast, rlast;

  assign full  = (cnt_q == CAP);
  assign empty = (cnt_q == '0);
  assign wlast = (wptr_q == LAST);
  assign rlast = (rptr_q == LAST);

  // Next-state logic
  always_comb begin
    wr_go  = wr_en & wtok_q & ~full;
    rd_go  = rd_en & rtok_q & ~empty;
    xo.wr  = wr_go & wlast;
    xo.rd  = rd_go & rlast;
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (wr_go) wptr_d = wlast ? '0 : wptr_q + 1'b1;
    if (rd_go) rptr_d = rlast ? '0 : rptr_q + 1'b1;
    case ({wr_go, rd_go})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    // Incoming token wins so a one-segment ring keeps its own tokens.
    wtok_d = xi.wr | (wtok_q & ~xo.wr);
    rtok_d = xi.rd | (rtok_q & ~xo.rd);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      wtok_q <= ~first_load_n;
      rtok_q <= ~first_load_n;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      wtok_q <= wtok_d;
      rtok_q <= rtok_d;
    end
  end

  assign wptr    = wptr_q;
  assign rptr    = rptr_q;
  assign wtok    = wtok_q;
  assign rtok    = rtok_q;
  assign full_n  = ~full;
  assign empty_n = ~empty;

  // R3: a blocked write leaves the write pointer where it was
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wtok_q && !full_n) |=> (wptr_q == $past(wptr_q)));

  // R4: a blocked read leaves the read pointer where it was
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rtok_q && !empty_n) |=> (rptr_q == $past(rptr_q)));

  // R5: a write hand-off drops the token and lasts one cycle
  p_wr_handoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xo.wr && !xi.wr) |=> (!wtok_q && !xo.wr));

  // R6: a read hand-off drops the token and lasts one cycle
  p_rd_handoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xo.rd && !xi.rd) |=> (!rtok_q && !xo.rd));

  // R7: occupancy never exceeds the segment depth
  always_comb begin
    if (rst_n) begin
      p_cnt_range_r7: assert (cnt_q <= CAP);
    end
  end
endmodule

// File: rtl/fdc_segment.sv
module fdc_segment
  import fdc_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          first_load_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  fdc_xp_t       xi,
  output fdc_xp_t       xo,
  output logic          rd_go,
  output logic [DW-1:0] rdata,
  output logic          wtok,
  output logic          rtok,
  output logic          full_n,
  output logic          empty_n
);
  logic          wr_go;
  logic [AW-1:0] wptr, rptr;

  fdc_seg_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .first_load_n (first_load_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .xi           (xi),
    .xo           (xo),
    .wr_go        (wr_go),
    .rd_go        (rd_go),
    .wptr         (wptr),
    .rptr         (rptr),
    .wtok         (wtok),
    .rtok         (rtok),
    .full_n       (full_n),
    .empty_n      (empty_n)
  );

  fdc_seg_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (wr_go),
    .waddr (wptr),
    .wdata (wr_data),
    .raddr (rptr),
    .rdata (rdata)
  );
endmodule

// File: rtl/fifo_depth_chain.sv
module fifo_depth_chain
  import fdc_pkg::*;
#(
  parameter int DW        = 8,
  parameter int DEPTH     = 4,
  parameter int NSEG      = 3,
  parameter int FIRST_SEG = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          full_n,
  output logic          empty_n
);
  fdc_xp_t       xo [NSEG];
  logic [DW-1:0] seg_rdata [NSEG];
  logic [NSEG-1:0] seg_rd_go, seg_wtok, seg_rtok, seg_full_n, seg_empty_n;

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    localparam int PREV = (i + NSEG - 1) % NSEG;
    fdc_segment #(.DW(DW), .DEPTH(DEPTH)) u_seg (
      .clk          (clk),
      .rst_n        (rst_n),
      .first_load_n ((i == FIRST_SEG) ? 1'b0 : 1'b1),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .rd_en        (rd_en),
      .xi           (xo[PREV]),
      .xo           (xo[i]),
      .rd_go        (seg_rd_go[i]),
      .rdata        (seg_rdata[i]),
      .wtok         (seg_wtok[i]),
      .rtok         (seg_rtok[i]),
      .full_n       (seg_full_n[i]),
      .empty_n      (seg_empty_n[i])
    );
  end

  // Composite flags: only the token holder's flag can block.
  logic [DW-1:0] rsel;
  always_comb begin
    full_n  = ~|(~seg_full_n  & seg_wtok);
    empty_n = ~|(~seg_empty_n & seg_rtok);
    rsel    = '0;
    for (int k = 0; k < NSEG; k++) begin
      rsel = rsel | (seg_rdata[k] & {DW{seg_rd_go[k]}});
    end
  end

  logic [DW-1:0] rd_data_q;
  logic          rd_valid_q;
  logic          any_rd;
  assign any_rd = |seg_rd_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= any_rd;
      if (any_rd) rd_data_q <= rsel;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;

  // R5: the write token lives in exactly one segment
  p_wtok_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(seg_wtok));

  // R6: the read token lives in exactly one segment
  p_rtok_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(seg_rtok));

  // R9: a read strobe against a non-empty queue yields valid data next cycle
  p_rd_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty_n) |=> rd_valid);

  // R4: a read strobe against an empty queue yields no data next cycle
  p_rd_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en || !empty_n) |=> !rd_valid);

  // R7: composite flags are never both asserted
  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!full_n && !empty_n));
endmodule

// File: tb/sim_fifo_depth_chain.sv
module sim_fifo_depth_chain;
  localparam int DW    = 8;
  localparam int DEPTH = 2;
  localparam int NSEG  = 3;
  localparam int CAP   = DEPTH * NSEG;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, rd_en;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic          rd_valid, full_n, empty_n;

  always #4 clk = ~clk;  // 125 MHz

  fifo_depth_chain #(.DW(DW), .DEPTH(DEPTH), .NSEG(NSEG)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .full_n(full_n), .empty_n(empty_n)
  );

  // {wr, rd, expected full_n, expected empty_n} after each cycle
  localparam logic [3:0] VEC [21] = '{
    4'b1011, 4'b1011, 4'b0111, 4'b1111, 4'b1011, 4'b1011, 4'b1011,
    4'b1011, 4'b1001, 4'b1001, 4'b0111, 4'b1001, 4'b0111, 4'b0111,
    4'b0111, 4'b0111, 4'b0111, 4'b0110, 4'b0110, 4'b1111, 4'b0110
  };

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] mq [256];
  int head = 0, tail = 0, count = 0;
  logic [DW-1:0] seq = 8'h10;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // One cycle of stimulus, called at a falling edge; checks after the next one.
  task automatic op(input bit w, input bit r, input string req);
    bit wacc, racc;
    logic [DW-1:0] exp;
    wacc = w && (count < CAP);
    racc = r && (count > 0);
    exp  = mq[head % 256];
    wr_en = w; rd_en = r; wr_data = seq;
    @(negedge clk);
    if (racc) begin head++; count--; end
    if (wacc) begin mq[tail % 256] = seq; tail++; count++; end
    if (w) seq = seq + 1'b1;
    check(rd_valid == racc, req, rd_valid, racc);
    if (racc) check(rd_data == exp, "R2 order", rd_data, exp);
    check(full_n == (count != CAP), "R7 full flag", full_n, count != CAP);
    check(empty_n == (count != 0), "R7 empty flag", empty_n, count != 0);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: flags during reset
    check(empty_n == 1'b0, "R1 empty_n in reset", empty_n, 0);
    check(full_n == 1'b1, "R1 full_n in reset", full_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);
    check(empty_n == 1'b0 && full_n == 1'b1, "R1 flags after reset", {full_n, empty_n}, 2'b10);

    // Table walk: R2 R3 R4 R7 R8 across segment boundaries
    for (int i = 0; i < 21; i++) begin
      op(VEC[i][3], VEC[i][2], "R9 rd_valid (table)");
      check(full_n == VEC[i][1], "R7 table full_n", full_n, VEC[i][1]);
      check(empty_n == VEC[i][0], "R7 table empty_n", empty_n, VEC[i][0]);
    end

    // R3: write at full ignored, contents intact
    repeat (CAP) op(1'b1, 1'b0, "R9 fill");
    check(full_n == 1'b0, "R3 full after NSEG*DEPTH writes", full_n, 0);
    op(1'b1, 1'b0, "R3 write while full");
    check(count == CAP && full_n == 1'b0, "R3 still full", full_n, 0);
    // R8: read+write while full -> only read accepted
    op(1'b1, 1'b1, "R8 rw at full");
    check(count == CAP - 1, "R8 only read taken at full", count, CAP - 1);
    repeat (CAP) op(1'b0, 1'b1, "R3 drain in order");
    // R4: read while empty ignored
    op(1'b0, 1'b1, "R4 read while empty");
    check(empty_n == 1'b0, "R4 still empty", empty_n, 0);

    // R10: steady stream over several laps, reads lagging writes
    for (int i = 0; i < 60; i++) begin
      op(1'b1, (i >= 3), "R10 stream");
    end
    while (count > 0) op(1'b0, 1'b1, "R10 drain");
    check(tail == head, "R10 no loss", tail - head, 0);

    // R1: reset mid-run discards stored words, first-load segment restarts
    repeat (3) op(1'b1, 1'b0, "R1 prefill");
    rst_n = 1'b0;
    @(negedge clk);
    check(empty_n == 1'b0 && full_n == 1'b1, "R1 flags on mid reset", {full_n, empty_n}, 2'b10);
    rst_n = 1'b1;
    head = 0; tail = 0; count = 0;
    @(negedge clk);
    op(1'b1, 1'b0, "R1 write after reset");
    op(1'b0, 1'b1, "R1 read after reset");
    check(empty_n == 1'b0, "R1 empty again", empty_n, 0);

    finish_run();
  end
endmodule